// File: doc/BRIEF.md
# Configuration-Space Serial EEPROM Bit-Bang Port

This block lets host software drive a three-wire serial EEPROM (select, clock, data toward the memory) purely through configuration-space accesses. Writes that land on two reserved configuration offsets are intercepted:

- One offset raises select and copies two bits of the written value onto the clock and data lines.
- The other offset drops all three lines.

Every other configuration write is forwarded, unchanged, to the normal configuration-space logic.

The serial data coming back from the EEPROM is returned on the read side. When the EEPROM output is low, a one-byte read of configuration offset zero has its low byte forced to zero. Software reads that byte repeatedly, one read per clock phase it has generated, to recover the serial bit stream.

A checksum walker validates an EEPROM image of 64 sixteen-bit words. The image comes either from an external synchronous word memory or from a built-in default image. The walker fetches one word per cycle and adds the words modulo 2^16. After the final word it reports whether the total matches the signature 0x1234. The built-in image computes its own last word so that it always passes.

Top module: `cfg_eeprom_port`

## Requirements
- R1: After synchronous reset, ee_cs, ee_sk, ee_di, fwd_wr_en, rd_valid, chk_busy and chk_done are all 0.
- R2: A write strobe at offset 0x80 sets ee_cs=1, ee_sk=bit 7 and ee_di=bit 6 of cfg_wr_data on the next clock edge. The write is not forwarded.
- R3: A write strobe at offset 0xC0 drives ee_cs, ee_sk and ee_di to 0 on the next clock edge. The write is not forwarded.
- R4: A write strobe at any other offset pulses fwd_wr_en for one cycle after the strobe edge, with the same address and data. The EEPROM pins are unchanged.
- R5: The EEPROM pins hold their levels in every cycle without a write strobe.
- R6: A read strobe with cfg_rd_byte=1 at offset 0x00 while ee_do=0 returns cfg_rd_raw with bits 7:0 cleared, one cycle after the strobe, with rd_valid=1.
- R7: Any other read returns cfg_rd_raw unchanged, one cycle after the strobe. This covers ee_do=1, a non-zero offset, or cfg_rd_byte=0.
- R8: A chk_start pulse makes the walker present word indices 0..63 on img_addr, one per cycle. It expects img_data one cycle after each index. chk_done rises on the 65th edge after the start edge.
- R9: chk_ok is 1 exactly when the 16-bit sum of the 64 words equals 0x1234. A single altered word makes it 0.
- R10: With chk_use_dflt=1 at start, the walker uses the built-in image and reports chk_ok=1. That image holds 0x0057 in words 0..15, 0x0F07 in word 32, 0x0400 in word 33 and 0x0007 in word 34, and a computed checksum in word 63.
- R11: chk_start while chk_busy=1 is ignored. chk_done stays set until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 8 | Configuration write offset |
| cfg_wr_data | input | 32 | Configuration write value |
| fwd_wr_en | output | 1 | Forwarded write strobe |
| fwd_wr_addr | output | 8 | Forwarded write offset |
| fwd_wr_data | output | 32 | Forwarded write value |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_rd_addr | input | 8 | Configuration read offset |
| cfg_rd_byte | input | 1 | Read is a single-byte access |
| cfg_rd_raw | input | 32 | Value from normal configuration space |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result |
| ee_cs | output | 1 | EEPROM select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Data toward EEPROM |
| ee_do | input | 1 | Data from EEPROM |
| chk_start | input | 1 | Start image checksum |
| chk_use_dflt | input | 1 | Walk the built-in default image |
| img_addr | output | 6 | Image word index |
| img_data | input | 16 | Image word, one cycle after img_addr |
| chk_busy | output | 1 | Walker running |
| chk_done | output | 1 | Walk finished |
| chk_ok | output | 1 | Image sum matched signature |

## Verification
The pin path is exercised with all four combinations of bits 7 and 6 at the select offset. Each pattern is followed by writes elsewhere that must leave the pins untouched, which separates interception from forwarding. The read gate is driven with ee_do low and high, with a non-zero offset and with a wide access, so each qualifier is shown to matter. The checksum walker sees a matching external image, the same image with one word changed, a start issued while busy, and the built-in image. Done latency is pinned to an exact edge.

// File: rtl/ee_port_pkg.sv
package ee_port_pkg;
  localparam int          IMG_WORDS = 64;
  localparam int          IMG_WW    = 16;
  localparam logic [15:0] IMG_SIG   = 16'h1234;

  // Built-in image contents without the checksum word.
  function automatic logic [15:0] dflt_raw(input int idx);
    logic [15:0] w;
    if (idx < 16)       w = 16'h0057;
    else if (idx == 32) w = 16'h0F07;  // adapter id 7, mode 0x0F
    else if (idx == 33) w = 16'h0400;  // tag count 4 in high byte
    else if (idx == 34) w = 16'h0007;  // option bits
    else                w = 16'h0000;
    return w;
  endfunction

  // Checksum word that makes the whole image sum to the signature.
  function automatic logic [15:0] dflt_ck(input int words);
    logic [15:0] s;
    s = '0;
    for (int i = 0; i < words - 1; i++) s = s + dflt_raw(i);
    return IMG_SIG - s;
  endfunction
endpackage

// File: rtl/ee_pin_ctrl.sv
module ee_pin_ctrl #(
  parameter int               AW        = 8,
  parameter int               DW        = 32,
  parameter logic [AW-1:0]    SEL_OFF   = 8'h80,
  parameter logic [AW-1:0]    DESEL_OFF = 8'hC0,
  parameter int               SK_BIT    = 7,
  parameter int               DI_BIT    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          ee_cs,
  output logic          ee_sk,
  output logic          ee_di,
  output logic          fwd_en,
  output logic [AW-1:0] fwd_addr,
  output logic [DW-1:0] fwd_data
);
  logic hit_sel, hit_desel;
  assign hit_sel   = wr_en && (wr_addr == SEL_OFF);
  assign hit_desel = wr_en && (wr_addr == DESEL_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      ee_cs <= 1'b0;
      ee_sk <= 1'b0;
      ee_di <= 1'b0;
    end else if (hit_sel) begin
      ee_cs <= 1'b1;
      ee_sk <= wr_data[SK_BIT];
      ee_di <= wr_data[DI_BIT];
    end else if (hit_desel) begin
      ee_cs <= 1'b0;
      ee_sk <= 1'b0;
      ee_di <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_en   <= 1'b0;
      fwd_addr <= '0;
      fwd_data <= '0;
    end else begin
      fwd_en <= wr_en && !hit_sel && !hit_desel;
      if (wr_en) begin
        fwd_addr <= wr_addr;
        fwd_data <= wr_data;
      end
    end
  end

  a_r2_sel_drive: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(wr_en) && $past(wr_addr) == SEL_OFF) |->
      (ee_cs && ee_sk == $past(wr_data[SK_BIT]) && ee_di == $past(wr_data[DI_BIT]) && !fwd_en));

  a_r3_desel_drive: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(wr_en) && $past(wr_addr) == DESEL_OFF) |->
      (!ee_cs && !ee_sk && !ee_di && !fwd_en));

  a_r5_pins_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(wr_en)) |-> $stable({ee_cs, ee_sk, ee_di}));

  a_r4_forward: assert property (@(posedge clk) disable iff (rst)
    fwd_en |-> (fwd_addr != SEL_OFF && fwd_addr != DESEL_OFF));
endmodule

// File: rtl/ee_rd_gate.sv
module ee_rd_gate #(
  parameter int            AW        = 8,
  parameter int            DW        = 32,
  parameter logic [AW-1:0] GATE_OFF  = 8'h00,
  parameter int            GATE_BITS = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_byte,
  input  logic [DW-1:0] rd_raw,
  input  logic          ee_do,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  localparam logic [DW-1:0] KEEP_MASK = ~{{(DW-GATE_BITS){1'b0}}, {GATE_BITS{1'b1}}};

  logic gate;
  assign gate = rd_byte && (rd_addr == GATE_OFF) && !ee_do;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= gate ? (rd_raw & KEEP_MASK) : rd_raw;
    end
  end

  a_r6_gated_low: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(rd_en) && $past(rd_byte) && $past(rd_addr) == GATE_OFF && !$past(ee_do))
      |-> (rd_valid && rd_data[GATE_BITS-1:0] == '0));

  a_r7_pass: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(rd_en) && $past(ee_do)) |-> (rd_valid && rd_data == $past(rd_raw)));
endmodule

// File: rtl/ee_img_checksum.sv
module ee_img_checksum
  import ee_port_pkg::*;
#(
  parameter int          WORDS = IMG_WORDS,
  parameter int          WW    = IMG_WW,
  parameter logic [15:0] SIG   = IMG_SIG,
  localparam int         IW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          use_dflt,
  output logic [IW-1:0] img_addr,
  input  logic [WW-1:0] img_data,
  output logic          busy,
  output logic          done,
  output logic          ok
);
  localparam logic [IW-1:0] LAST  = IW'(WORDS - 1);
  localparam logic [15:0]   DFLT_CK = dflt_ck(WORDS);

  logic [IW-1:0] rd_idx;
  logic          issuing, pend, pend_last, dflt_sel;
  logic [WW-1:0] sum, dflt_q, word_in, sum_nx;

  assign img_addr = rd_idx;
  assign busy     = issuing || pend;
  assign word_in  = dflt_sel ? dflt_q : img_data;
  assign sum_nx   = sum + word_in;

  // Built-in image ROM with the same one-cycle latency as the external memory.
  always_ff @(posedge clk) begin
    if (rd_idx == LAST) dflt_q <= WW'(DFLT_CK);
    else                dflt_q <= WW'(dflt_raw(int'(rd_idx)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_idx    <= '0;
      issuing   <= 1'b0;
      pend      <= 1'b0;
      pend_last <= 1'b0;
      dflt_sel  <= 1'b0;
      sum       <= '0;
      done      <= 1'b0;
      ok        <= 1'b0;
    end else begin
      pend      <= issuing;
      pend_last <= issuing && (rd_idx == LAST);
      if (start && !busy) begin
        rd_idx   <= '0;
        issuing  <= 1'b1;
        dflt_sel <= use_dflt;
        sum      <= '0;
        done     <= 1'b0;
        ok       <= 1'b0;
      end else if (issuing) begin
        if (rd_idx == LAST) issuing <= 1'b0;
        else                rd_idx  <= rd_idx + 1'b1;
      end
      if (pend) begin
        sum <= sum_nx;
        if (pend_last) begin
          done <= 1'b1;
          ok   <= (16'(sum_nx) == SIG);
        end
      end
    end
  end

  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r11_done_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(done) && !$past(start && !busy)) |-> done);

  a_r8_addr_step: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(issuing) && issuing) |-> (img_addr == $past(img_addr) + 1'b1));

  a_r9_ok_with_done: assert property (@(posedge clk) disable iff (rst)
    ok |-> done);
endmodule

// File: rtl/cfg_eeprom_port.sv
module cfg_eeprom_port
  import ee_port_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int WORDS = IMG_WORDS,
  parameter int WW = IMG_WW,
  localparam int IW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr_en,
  input  logic [AW-1:0] cfg_wr_addr,
  input  logic [DW-1:0] cfg_wr_data,
  output logic          fwd_wr_en,
  output logic [AW-1:0] fwd_wr_addr,
  output logic [DW-1:0] fwd_wr_data,
  input  logic          cfg_rd_en,
  input  logic [AW-1:0] cfg_rd_addr,
  input  logic          cfg_rd_byte,
  input  logic [DW-1:0] cfg_rd_raw,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          ee_cs,
  output logic          ee_sk,
  output logic          ee_di,
  input  logic          ee_do,
  input  logic          chk_start,
  input  logic          chk_use_dflt,
  output logic [IW-1:0] img_addr,
  input  logic [WW-1:0] img_data,
  output logic          chk_busy,
  output logic          chk_done,
  output logic          chk_ok
);
  ee_pin_ctrl #(.AW(AW), .DW(DW)) u_pins (
    .clk(clk), .rst(rst),
    .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_data(cfg_wr_data),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .fwd_en(fwd_wr_en), .fwd_addr(fwd_wr_addr), .fwd_data(fwd_wr_data)
  );

  ee_rd_gate #(.AW(AW), .DW(DW)) u_rd (
    .clk(clk), .rst(rst),
    .rd_en(cfg_rd_en), .rd_addr(cfg_rd_addr), .rd_byte(cfg_rd_byte),
    .rd_raw(cfg_rd_raw), .ee_do(ee_do),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  ee_img_checksum #(.WORDS(WORDS), .WW(WW)) u_chk (
    .clk(clk), .rst(rst),
    .start(chk_start), .use_dflt(chk_use_dflt),
    .img_addr(img_addr), .img_data(img_data),
    .busy(chk_busy), .done(chk_done), .ok(chk_ok)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!ee_cs && !ee_sk && !ee_di && !fwd_wr_en && !rd_valid && !chk_done));
endmodule

// File: tb/sim_cfg_eeprom_port.sv
module sim_cfg_eeprom_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1;
  logic        cfg_wr_en = 0, cfg_rd_en = 0, cfg_rd_byte = 0, ee_do = 0;
  logic [7:0]  cfg_wr_addr = 0, cfg_rd_addr = 0, fwd_wr_addr;
  logic [31:0] cfg_wr_data = 0, cfg_rd_raw = 0, fwd_wr_data, rd_data;
  logic        fwd_wr_en, rd_valid, ee_cs, ee_sk, ee_di;
  logic        chk_start = 0, chk_use_dflt = 0, chk_busy, chk_done, chk_ok;
  logic [5:0]  img_addr;
  logic [15:0] img_data;
  logic [15:0] mem [64];

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) img_data <= mem[img_addr];

  cfg_eeprom_port u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    cfg_wr_en = 1; cfg_wr_addr = a; cfg_wr_data = d;
    tick();
    cfg_wr_en = 0;
  endtask

  task automatic t_reset();
    rst = 1; tick(); tick(); rst = 0;
    check("R1 pins", {ee_cs, ee_sk, ee_di}, 0);
    check("R1 flags", {fwd_wr_en, rd_valid, chk_busy, chk_done}, 0);
  endtask

  task automatic t_select();
    for (int p = 0; p < 4; p++) begin
      cfg_write(8'h80, {24'h0, p[1:0], 6'h15});
      check("R2 pins", {ee_cs, ee_sk, ee_di}, {1'b1, p[1:0]});
      check("R2 no fwd", fwd_wr_en, 0);
    end
  endtask

  task automatic t_forward();
    cfg_write(8'h80, 32'hC0);
    cfg_write(8'h3C, 32'hDEADBEEF);
    check("R4 fwd", {fwd_wr_en, fwd_wr_addr, fwd_wr_data}, {1'b1, 8'h3C, 32'hDEADBEEF});
    check("R4 pins", {ee_cs, ee_sk, ee_di}, 3'b111);
    tick();
    check("R4 one pulse", fwd_wr_en, 0);
    check("R5 hold", {ee_cs, ee_sk, ee_di}, 3'b111);
    cfg_write(8'h81, 32'h0);
    check("R4 near offset", {fwd_wr_en, ee_cs, ee_sk, ee_di}, 4'b1111);
  endtask

  task automatic t_deselect();
    cfg_write(8'hC0, 32'hFFFFFFFF);
    check("R3 pins", {ee_cs, ee_sk, ee_di}, 0);
    check("R3 no fwd", fwd_wr_en, 0);
  endtask

  task automatic rd(input logic [7:0] a, input logic b, input logic d, input logic [31:0] raw,
                    input logic [31:0] exp, input string req);
    cfg_rd_en = 1; cfg_rd_addr = a; cfg_rd_byte = b; ee_do = d; cfg_rd_raw = raw;
    tick();
    cfg_rd_en = 0;
    check(req, {31'h0, rd_valid}, 1);
    check(req, rd_data, exp);
  endtask

  task automatic t_reads();
    rd(8'h00, 1, 0, 32'h1234_5A5A, 32'h1234_5A00, "R6 gated");
    rd(8'h00, 1, 1, 32'h1234_5A5A, 32'h1234_5A5A, "R7 do high");
    rd(8'h04, 1, 0, 32'h0000_00FF, 32'h0000_00FF, "R7 other offset");
    rd(8'h00, 0, 0, 32'hA5A5_A5A5, 32'hA5A5_A5A5, "R7 wide access");
  endtask

  task automatic run_chk(input logic dflt, input logic exp_ok, input string req);
    chk_use_dflt = dflt; chk_start = 1;
    tick();
    chk_start = 0;
    check("R8 busy", chk_busy, 1);
    for (int i = 1; i < 65; i++) begin
      if (i == 10) begin chk_start = 1; tick(); chk_start = 0; end
      else tick();
    end
    check("R8 not early", chk_done, 0);
    tick();
    check("R8 done edge", chk_done, 1);
    check(req, chk_ok, exp_ok);
    tick(); tick();
    check("R11 done holds", {chk_done, chk_busy}, 2'b10);
  endtask

  task automatic build_default();
    logic [15:0] s;
    s = 0;
    for (int i = 0; i < 64; i++) mem[i] = 0;
    for (int i = 0; i < 16; i++) mem[i] = 16'h0057;
    mem[32] = 16'h0F07; mem[33] = 16'h0400; mem[34] = 16'h0007;
    for (int i = 0; i < 63; i++) s = s + mem[i];
    mem[63] = 16'h1234 - s;
  endtask

  task automatic t_checksum();
    build_default();
    run_chk(0, 1, "R9 good image");
    mem[20] = mem[20] ^ 16'h0100;
    run_chk(0, 0, "R9 altered word");
    for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
    run_chk(1, 1, "R10 builtin image");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 0;
    @(negedge clk);
    t_reset();
    t_select();
    t_forward();
    t_deselect();
    t_reads();
    t_checksum();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule